// File: doc/BRIEF.md
# Cycle-stealing DMA controller

This block copies a block of words between one peripheral data port and memory while the processor keeps running. Software loads a memory start address, a word count and a device address, then writes the control register with the start bit and the direction. From then on the block works alone. For each word it asks the bus arbiter for the bus and waits for the grant. It uses the bus for exactly one cycle, then drops its request. The processor therefore loses only the single bus cycle in which a word moves and never changes context.

The peripheral side uses two valid/ready streams. Words from the device arrive on the `rx` stream. The block raises `rx_ready` only while it is waiting for the next word, and a word moves when `rx_valid` and `rx_ready` are both high at a clock edge. Words for the device leave on the `tx` stream. Once `tx_valid` is raised, it stays high and `tx_data` stays unchanged until `tx_ready` is sampled high, so the device may apply back-pressure for any number of cycles. When the last word has moved, the block raises a level interrupt, which stays high until software clears it.

Top module: `cs_dma`

## Requirements
- R1: After reset, `busy`, `done_irq`, `bus_req`, `rx_ready` and `tx_valid` are low, and while `busy` is low none of `bus_req`, `rx_ready` or `tx_valid` is ever high.
- R2: Register selects: 1 is the device address, 2 is the memory start address, 3 is the word count, and 0 is control. In the control register, bit 0 is start, bit 1 clears the interrupt, and bit 2 gives the direction (0 = device to memory, 1 = memory to device). A start write with a non-zero count makes `busy` high from the next cycle on.
- R3: `bus_req` rises only after a device word has been accepted (direction 0) or while the device shows `tx_ready` (direction 1). `bus_en` is never high unless `bus_gnt` and `bus_req` are both high.
- R4: Each bus tenure carries exactly one word: the cycle after `bus_en` is high has neither `bus_en` nor `bus_req` high, and a transfer of N words gives exactly N `bus_en` cycles.
- R5: The memory addresses of a transfer are start, start+1, ... start+N-1, in that order.
- R6: In direction 0, the i-th word accepted on `rx` is written (`bus_we` high) to memory address start+i.
- R7: In direction 1, the word read at address start+i is the i-th word sent on `tx`, and `tx_data` holds steady while `tx_valid` is high and `tx_ready` is low.
- R8: `done_irq` rises on the same edge at which `busy` falls after the last word, and stays high until a control write with bit 1 set.
- R9: If a clear write falls in the same cycle as a completion, the interrupt ends up set.
- R10: A start write while `busy` is high is ignored, and register writes during a transfer do not change its address, count, direction or device.
- R11: A start with a count of zero sets `done_irq` on the same edge, leaves `busy` low and never raises `bus_req`.
- R12: `dev_sel` carries the device address held at start for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | Completion interrupt (level) |
| dev_sel | output | DVW | Device address of the running transfer |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_en | output | 1 | Bus cycle strobe |
| bus_we | output | 1 | Bus cycle writes memory |
| bus_addr | output | AW | Memory address |
| bus_wdata | output | DW | Memory write data |
| bus_rdata | input | DW | Memory read data, valid during the bus cycle |
| rx_valid | input | 1 | Device word available |
| rx_data | input | DW | Device word |
| rx_ready | output | 1 | Controller accepts a device word |
| tx_valid | output | 1 | Word offered to the device |
| tx_data | output | DW | Word for the device |
| tx_ready | input | 1 | Device accepts the word |

## Verification
The completion of the last word and the software clear of the interrupt can land on the same clock edge. If the clear took precedence, a finished transfer would go unreported. The bench provokes this with a one-word transfer. It watches for the cycle in which `bus_en` is high, which is the completing cycle, and issues the clear write in exactly that cycle. It then expects `done_irq` high and `busy` low at the next sample, and checks that a later plain clear still brings the interrupt down.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_XFER,
    ST_SEND
  } dma_st_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DEV  = 2'd1;
  localparam logic [1:0] SEL_MEM  = 2'd2;
  localparam logic [1:0] SEL_CNT  = 2'd3;

  localparam int BIT_GO  = 0;
  localparam int BIT_ACK = 1;
  localparam int BIT_DIR = 2;
endpackage

// File: rtl/cs_dma_regs.sv
module cs_dma_regs
  import cs_dma_pkg::*;
#(
  parameter int AW  = 16,
  parameter int CW  = 8,
  parameter int DVW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_addr,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic           busy,
  input  logic           done,
  output logic           start,
  output logic           go_dir,
  output logic [DVW-1:0] dev_cfg,
  output logic [AW-1:0]  mem_cfg,
  output logic [CW-1:0]  cnt_cfg,
  output logic           irq
);
  logic ctrl_wr;
  logic clr;

  assign ctrl_wr = cfg_we && (cfg_addr == SEL_CTRL);
  assign start   = ctrl_wr && cfg_wdata[BIT_GO] && !busy;
  assign clr     = ctrl_wr && cfg_wdata[BIT_ACK];
  assign go_dir  = cfg_wdata[BIT_DIR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_cfg <= '0;
      mem_cfg <= '0;
      cnt_cfg <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        SEL_DEV: dev_cfg <= cfg_wdata[DVW-1:0];
        SEL_MEM: mem_cfg <= cfg_wdata;
        SEL_CNT: cnt_cfg <= cfg_wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  // completion has precedence over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq <= 1'b0;
    else if (done)   irq <= 1'b1;
    else if (clr)    irq <= 1'b0;
  end
endmodule

// File: rtl/cs_dma_ptr.sv
module cs_dma_ptr #(
  parameter int AW  = 16,
  parameter int CW  = 8,
  parameter int DVW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [AW-1:0]  mem_cfg,
  input  logic [CW-1:0]  cnt_cfg,
  input  logic [DVW-1:0] dev_cfg,
  output logic [AW-1:0]  addr_q,
  output logic [CW-1:0]  cnt_q,
  output logic [DVW-1:0] dev_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      dev_q  <= '0;
    end else if (load) begin
      addr_q <= mem_cfg;
      cnt_q  <= cnt_cfg;
      dev_q  <= dev_cfg;
    end else if (step) begin
      addr_q <= addr_q + AW'(1);
      cnt_q  <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/cs_dma_seq.sv
module cs_dma_seq
  import cs_dma_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          go_dir,
  input  logic          cfg_zero,
  input  logic [CW-1:0] cnt,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic          bus_en,
  output logic          bus_we,
  output logic [DW-1:0] bus_wdata,
  output logic          load,
  output logic          step,
  output logic          done,
  output logic          busy
);
  dma_st_e       st_q, st_d;
  logic          dir_q;
  logic [DW-1:0] word_q;

  always_comb begin
    st_d     = st_q;
    rx_ready = 1'b0;
    tx_valid = 1'b0;
    bus_req  = 1'b0;
    bus_en   = 1'b0;
    load     = 1'b0;
    step     = 1'b0;
    done     = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        if (cfg_zero) done = 1'b1;
        else begin
          load = 1'b1;
          st_d = ST_WAIT;
        end
      end
      ST_WAIT: if (dir_q) begin
        if (tx_ready) st_d = ST_REQ;
      end else begin
        rx_ready = 1'b1;
        if (rx_valid) st_d = ST_REQ;
      end
      ST_REQ: begin
        bus_req = 1'b1;
        if (bus_gnt) st_d = ST_XFER;
      end
      ST_XFER: begin
        bus_req = 1'b1;
        bus_en  = 1'b1;
        step    = 1'b1;
        if (dir_q) st_d = ST_SEND;
        else if (cnt == CW'(1)) begin
          done = 1'b1;
          st_d = ST_IDLE;
        end else st_d = ST_WAIT;
      end
      ST_SEND: begin
        tx_valid = 1'b1;
        if (tx_ready) begin
          if (cnt == '0) begin
            done = 1'b1;
            st_d = ST_IDLE;
          end else st_d = ST_WAIT;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign bus_we    = bus_en && !dir_q;
  assign bus_wdata = word_q;
  assign tx_data   = word_q;
  assign busy      = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dir_q  <= 1'b0;
      word_q <= '0;
    end else begin
      st_q <= st_d;
      if (load) dir_q <= go_dir;
      if (st_q == ST_WAIT && !dir_q && rx_valid) word_q <= rx_data;
      else if (st_q == ST_XFER && dir_q)         word_q <= bus_rdata;
    end
  end
endmodule

// File: rtl/cs_dma.sv
module cs_dma #(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int CW  = 8,
  parameter int DVW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_addr,
  input  logic [AW-1:0]  cfg_wdata,
  output logic           busy,
  output logic           done_irq,
  output logic [DVW-1:0] dev_sel,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           bus_en,
  output logic           bus_we,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  input  logic           rx_valid,
  input  logic [DW-1:0]  rx_data,
  output logic           rx_ready,
  output logic           tx_valid,
  output logic [DW-1:0]  tx_data,
  input  logic           tx_ready
);
  logic           start, go_dir, load, step, done;
  logic [DVW-1:0] dev_cfg;
  logic [AW-1:0]  mem_cfg;
  logic [CW-1:0]  cnt_cfg, cnt_q;

  cs_dma_regs #(.AW(AW), .CW(CW), .DVW(DVW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .done(done), .start(start),
    .go_dir(go_dir), .dev_cfg(dev_cfg), .mem_cfg(mem_cfg),
    .cnt_cfg(cnt_cfg), .irq(done_irq)
  );

  cs_dma_ptr #(.AW(AW), .CW(CW), .DVW(DVW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .mem_cfg(mem_cfg), .cnt_cfg(cnt_cfg), .dev_cfg(dev_cfg),
    .addr_q(bus_addr), .cnt_q(cnt_q), .dev_q(dev_sel)
  );

  cs_dma_seq #(.DW(DW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .go_dir(go_dir),
    .cfg_zero(cnt_cfg == '0), .cnt(cnt_q),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .bus_req(bus_req),
    .bus_en(bus_en), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .load(load), .step(step), .done(done), .busy(busy)
  );
endmodule

// File: rtl/cs_dma_chk.sv
module cs_dma_chk #(
  parameter int DW  = 8,
  parameter int DVW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done_irq,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic           bus_en,
  input logic           rx_ready,
  input logic           tx_valid,
  input logic           tx_ready,
  input logic [DW-1:0]  tx_data,
  input logic [DVW-1:0] dev_sel,
  input logic           clr_wr
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !rx_ready && !tx_valid));
  // R3
  en_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> (bus_gnt && bus_req));
  // R4
  one_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |=> (!bus_req && !bus_en));
  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R8
  irq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && !clr_wr) |=> done_irq);
  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_irq);
  // R12
  dev_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dev_sel));
endmodule

bind cs_dma cs_dma_chk #(.DW(DW), .DVW(DVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done_irq(done_irq),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_en(bus_en),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .dev_sel(dev_sel),
  .clr_wr(cfg_we && cfg_addr == 2'd0 && cfg_wdata[1])
);

// File: tb/cs_dma_bench.sv
module cs_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        busy, done_irq, bus_req, bus_en, bus_we, rx_ready, tx_valid;
  logic [3:0]  dev_sel;
  logic        bus_gnt = 1'b0;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata, tx_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tx_ready = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic [7:0]  src_salt = 8'h00;
  logic [3:0]  exp_dev = '0;
  bit          tx_allow = 1'b0;
  int          rx_quota = 0, rx_idx = 0;
  bit          rx_fire = 1'b0;
  int          en_cnt = 0, tx_cnt = 0, req_cnt = 0, dev_err = 0;
  logic [15:0] addr_log [0:511];
  logic [7:0]  tx_log [0:511];
  logic [7:0]  dmem [0:255];

  always #5 clk = ~clk;

  cs_dma u_cs_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .done_irq(done_irq),
    .dev_sel(dev_sel), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready)
  );

  function automatic logic [7:0] src_word(input logic [15:0] a, input logic [7:0] s);
    return (a[7:0] * 8'd37) ^ s;
  endfunction
  function automatic logic [7:0] rx_word(input int i);
    return 8'(i * 53 + 7) ^ 8'h5a;
  endfunction

  assign bus_rdata = (bus_addr[7:0] * 8'd37) ^ src_salt;

  always @(posedge clk) begin
    if (bus_en === 1'b1) begin
      addr_log[en_cnt[8:0]] <= bus_addr;
      en_cnt <= en_cnt + 1;
      if (bus_we) dmem[bus_addr[7:0]] <= bus_wdata;
    end
    if (tx_valid === 1'b1 && tx_ready) begin
      tx_log[tx_cnt[8:0]] <= tx_data;
      tx_cnt <= tx_cnt + 1;
    end
    rx_fire <= (rx_valid && rx_ready === 1'b1);
    if (bus_req === 1'b1) req_cnt <= req_cnt + 1;
    if (busy === 1'b1 && dev_sel != exp_dev) dev_err <= dev_err + 1;
  end

  always @(negedge clk) begin
    if (rx_fire) begin
      rx_valid = 1'b0;
      rx_idx++;
    end
    if (!rx_valid && rx_idx < rx_quota && $urandom_range(0, 2) != 0) begin
      rx_valid = 1'b1;
      rx_data  = rx_word(rx_idx);
    end
    tx_ready = tx_allow && ($urandom_range(0, 3) != 0);
    bus_gnt  = (bus_req === 1'b1) && (bus_gnt || $urandom_range(0, 2) == 0);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
    chk(!busy, "R8", "transfer finished in time", int'(busy), 0);
  endtask

  task automatic run_xfer(input bit dir, input int n, input logic [15:0] base,
                          input logic [3:0] dev, input bit meddle);
    int en0, tx0, rx0, rq0, de0;
    bit ok;
    src_salt = 8'($urandom);
    cfg_write(2'd1, {12'd0, dev});
    cfg_write(2'd2, base);
    cfg_write(2'd3, 16'(n));
    exp_dev = dev;
    en0 = en_cnt; tx0 = tx_cnt; rx0 = rx_idx; de0 = dev_err;
    tx_allow = !meddle;
    if (!dir && !meddle) rx_quota = rx0 + n;
    cfg_write(2'd0, {13'd0, dir, 2'b01});
    // R2: start with non-zero count makes busy
    chk(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
    if (meddle) begin
      rq0 = req_cnt;
      repeat (20) @(negedge clk);
      // R3: no request without a device word / device readiness
      chk(req_cnt == rq0, "R3", "no bus_req while device idle", req_cnt - rq0, 0);
      // R10: disturb registers and retry start while busy
      cfg_write(2'd2, base + 16'd40);
      cfg_write(2'd3, 16'd3);
      cfg_write(2'd1, {12'd0, ~dev});
      cfg_write(2'd0, {13'd0, !dir, 2'b01});
      chk(busy === 1'b1 && en_cnt == en0, "R10", "transfer unchanged by writes",
          en_cnt - en0, 0);
      tx_allow = 1'b1;
      if (!dir) rx_quota = rx0 + n;
    end
    wait_idle();
    chk(done_irq === 1'b1, "R8", "irq after last word", int'(done_irq), 1);
    chk(en_cnt - en0 == n, "R4", "bus cycles per transfer", en_cnt - en0, n);
    ok = 1'b1;
    for (int i = 0; i < n; i++)
      if (addr_log[(en0 + i) % 512] != base + 16'(i)) ok = 1'b0;
    chk(ok, "R5", "consecutive addresses", int'(ok), 1);
    ok = 1'b1;
    if (!dir) begin
      for (int i = 0; i < n; i++)
        if (dmem[8'(base + 16'(i))] != rx_word(rx0 + i)) ok = 1'b0;
      chk(ok, "R6", "device words stored in memory", int'(ok), 1);
    end else begin
      for (int i = 0; i < n; i++)
        if (tx_log[(tx0 + i) % 512] != src_word(base + 16'(i), src_salt)) ok = 1'b0;
      chk(ok && tx_cnt - tx0 == n, "R7", "memory words sent to device",
          tx_cnt - tx0, n);
    end
    chk(dev_err == de0, "R12", "dev_sel during transfer", dev_err - de0, 0);
    repeat (3) @(negedge clk);
    // R8 persistence; R10 no deferred restart
    chk(done_irq === 1'b1, "R8", "irq held without clear", int'(done_irq), 1);
    chk(!busy, "R10", "start during busy not queued", int'(busy), 0);
    cfg_write(2'd0, 16'h0002);
    chk(done_irq === 1'b0, "R8", "irq cleared", int'(done_irq), 0);
  endtask

  initial begin
    int rq0;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done_irq && !bus_req && !rx_ready && !tx_valid, "R1",
        "reset outputs quiet", int'({busy, done_irq, bus_req, rx_ready, tx_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done_irq, "R1", "idle after reset", int'({busy, done_irq}), 0);

    // directed corner cases
    run_xfer(1'b0, 4, 16'd10, 4'h3, 1'b0);
    run_xfer(1'b1, 5, 16'd60, 4'hA, 1'b0);
    run_xfer(1'b0, 3, 16'd100, 4'h5, 1'b1);
    run_xfer(1'b1, 2, 16'd130, 4'hC, 1'b1);
    run_xfer(1'b1, 1, 16'd200, 4'h1, 1'b0);

    // R11: zero count completes at once without a request
    cfg_write(2'd3, 16'd0);
    rq0 = req_cnt;
    cfg_write(2'd0, 16'h0001);
    chk(done_irq === 1'b1 && !busy, "R11", "zero count done at once",
        int'({done_irq, busy}), 2);
    repeat (4) @(negedge clk);
    chk(req_cnt == rq0 && !busy, "R11", "zero count no bus_req", req_cnt - rq0, 0);
    cfg_write(2'd0, 16'h0002);

    // R9: clear write in the completing cycle; completion must win
    cfg_write(2'd1, 16'h0007);
    cfg_write(2'd2, 16'd220);
    cfg_write(2'd3, 16'd1);
    rx_quota = rx_idx + 1;
    cfg_write(2'd0, 16'h0001);
    for (int k = 0; k < 500 && bus_en !== 1'b1; k++) @(negedge clk);
    chk(bus_en === 1'b1, "R9", "reached completing cycle", int'(bus_en), 1);
    cfg_write(2'd0, 16'h0002);
    chk(done_irq === 1'b1 && !busy, "R9", "set wins over clear",
        int'({done_irq, busy}), 2);
    cfg_write(2'd0, 16'h0002);
    chk(done_irq === 1'b0, "R9", "later clear works", int'(done_irq), 0);

    // constrained random transfers
    for (int t = 0; t < 12; t++)
      run_xfer(1'($urandom), int'($urandom_range(1, 12)),
               16'($urandom_range(0, 240)), 4'($urandom), 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule